// File: doc/BRIEF.md
# Polled Device Input Port

This block is the peripheral side of a programmed-input device on a shared I/O bus. The CPU places a device address on the bus and raises its input-phase signal. The port compares that address with its own fixed address. When the address matches during the input phase, the port puts its held data word on the shared data bus. If its ready flag is also set, it pulls the active-low skip line low. The CPU can then take the word and skip its next instruction.

A local producer loads a data word with a one-cycle load pulse, which sets the ready flag. The CPU then pulses a strobe. When that strobe falls while the port is still selected, the ready flag clears. The data word stays on the bus for as long as the address match and the input phase both hold. The bus driver is modelled as a drive-enable plus a data vector, and the data vector is zero whenever the enable is low.

Top module: `polled_input_port`

## Requirements
- R1: After reset, and whenever reset is asserted, `ready` is 0, `skip_n` is 1, and the held word is 0. If the port is selected during reset, it drives a zero word.
- R2: `skip_n` is 0 exactly when `bus_addr` equals `DEV_ADDR`, `in_phase` is 1 and `ready` is 1. Otherwise it is 1.
- R3: `bus_drive` is 1 exactly when `bus_addr` equals `DEV_ADDR` and `in_phase` is 1. This holds regardless of `ready` and `cpu_strobe`. While `bus_drive` is 1, `bus_data` carries the held word.
- R4: `bus_data` is all zeros whenever `bus_drive` is 0.
- R5: A `load` pulse sampled while `ready` is 0 captures `load_data` as the held word and sets `ready`, both visible after that clock edge.
- R6: A `load` pulse sampled while `ready` is 1 is ignored. The held word and `ready` keep their values, and this includes the cycle in which a strobe clears `ready`.
- R7: `ready` clears on the clock edge at which `cpu_strobe` is sampled 0, when it was sampled 1 on the previous edge and the port is selected (address match and `in_phase` 1). While the strobe is high, `ready` stays set.
- R8: A strobe whose falling sample occurs while the address does not match, or while `in_phase` is 0, leaves `ready` unchanged.
- R9: After `ready` clears, the port keeps driving the same word for as long as it stays selected, while `skip_n` returns to 1.
- R10: Only an exact match of `bus_addr` with `DEV_ADDR` selects the port. A neighbouring address neither drives data nor asserts skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Device address presented by the CPU |
| in_phase | input | 1 | CPU input-transfer phase, active high |
| cpu_strobe | input | 1 | CPU strobe, active high; its trailing edge is used |
| load | input | 1 | Producer load pulse |
| load_data | input | DATA_W | Producer data word |
| skip_n | output | 1 | Active-low skip/test line |
| bus_drive | output | 1 | Data bus drive enable |
| bus_data | output | DATA_W | Data bus value, zero when not driving |
| ready | output | 1 | Ready flag |

## Verification
The assertions check these rules on every cycle:
- A low skip line implies both bus drive and ready.
- An idle driver outputs zero data.
- An accepted load raises ready.
- Ready cannot fall while the strobe is high or while the port is not selected.

The bench scenarios cover what a property cannot show in general:
- The exact word that is captured, and that it persists after ready clears.
- That a load is ignored while ready is set.
- The exact cycle at which the trailing strobe edge clears the flag.
- Reset in the middle of a transfer.

// File: rtl/polled_input_port.sv
module polled_input_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              in_phase,
  input  logic              cpu_strobe,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              skip_n,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_data,
  output logic              ready
);

  logic              sel;
  logic              strobe_q;
  logic              strobe_trail;
  logic              ready_q;
  logic [DATA_W-1:0] hold_q;

  assign sel          = (bus_addr == DEV_ADDR) && in_phase;
  assign strobe_trail = strobe_q && !cpu_strobe && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      ready_q  <= 1'b0;
      hold_q   <= '0;
    end else begin
      strobe_q <= cpu_strobe;
      if (ready_q) begin
        if (strobe_trail) ready_q <= 1'b0;
      end else if (load) begin
        ready_q <= 1'b1;
        hold_q  <= load_data;
      end
    end
  end

  assign skip_n    = !(sel && ready_q);
  assign bus_drive = sel;
  assign bus_data  = sel ? hold_q : '0;
  assign ready     = ready_q;

endmodule

// File: rtl/port_checker.sv
module port_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'h15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              in_phase,
  input logic              cpu_strobe,
  input logic              load,
  input logic              skip_n,
  input logic              bus_drive,
  input logic [DATA_W-1:0] bus_data,
  input logic              ready
);

  logic picked;
  assign picked = (bus_addr == DEV_ADDR) && in_phase;

  assert_skip_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_n |-> (bus_drive && ready));

  assert_drive_follows_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive == picked);

  assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_data == '0));

  assert_load_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ready) |=> ready);

  assert_hold_while_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cpu_strobe) |=> ready);

  assert_no_clear_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !picked) |=> ready);

endmodule

bind polled_input_port port_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)
) u_chk (.*);

// File: tb/tb_polled_input_port.sv
module tb_polled_input_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [AW-1:0] ME = 6'h15;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          ph;
    logic          stb;
    logic          ld;
    logic [DW-1:0] ldat;
    logic          e_skip;
    logic          e_drv;
    logic [DW-1:0] e_dat;
    logic          e_rdy;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{ME,    1,0,0,16'h0000, 1,1,16'h0000,0},
    '{6'h00, 0,0,1,16'hA5A5, 1,0,16'h0000,0},
    '{ME,    1,0,0,16'h0000, 0,1,16'hA5A5,1},
    '{6'h14, 1,0,0,16'h0000, 1,0,16'h0000,1},
    '{ME,    0,0,0,16'h0000, 1,0,16'h0000,1},
    '{ME,    1,0,1,16'h1234, 0,1,16'hA5A5,1},
    '{ME,    1,0,0,16'h0000, 0,1,16'hA5A5,1},
    '{6'h14, 1,1,0,16'h0000, 1,0,16'h0000,1},
    '{6'h14, 1,0,0,16'h0000, 1,0,16'h0000,1},
    '{ME,    1,0,0,16'h0000, 0,1,16'hA5A5,1},
    '{ME,    0,1,0,16'h0000, 1,0,16'h0000,1},
    '{ME,    0,0,0,16'h0000, 1,0,16'h0000,1},
    '{ME,    1,0,0,16'h0000, 0,1,16'hA5A5,1},
    '{ME,    1,1,0,16'h0000, 0,1,16'hA5A5,1},
    '{ME,    1,0,0,16'h0000, 0,1,16'hA5A5,1},
    '{ME,    1,0,0,16'h0000, 1,1,16'hA5A5,0},
    '{ME,    1,0,1,16'h0F0F, 1,1,16'hA5A5,0},
    '{ME,    1,0,0,16'h0000, 0,1,16'h0F0F,1},
    '{6'h00, 0,0,0,16'h0000, 1,0,16'h0000,1}
  };

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          in_phase = 0, cpu_strobe = 0, load = 0;
  logic [DW-1:0] load_data = '0;
  logic          skip_n, bus_drive, ready;
  logic [DW-1:0] bus_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  polled_input_port #(.ADDR_W(AW), .DATA_W(DW), .DEV_ADDR(ME)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .in_phase(in_phase),
    .cpu_strobe(cpu_strobe), .load(load), .load_data(load_data),
    .skip_n(skip_n), .bus_drive(bus_drive), .bus_data(bus_data), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic p, input logic s,
                       input logic l, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; in_phase = p; cpu_strobe = s; load = l; load_data = d;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state, selected during reset
    drive(ME, 1, 0, 0, '0);
    chk("R1 ready", {15'b0, ready}, 16'h0);
    chk("R1 skip_n", {15'b0, skip_n}, 16'h1);
    chk("R1 data", bus_data, 16'h0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].addr, VECS[i].ph, VECS[i].stb, VECS[i].ld, VECS[i].ldat);
      // R2 R3 R4 R5 R6 R7 R8 R9 R10 across the table
      chk($sformatf("R2 skip_n v%0d", i), {15'b0, skip_n}, {15'b0, VECS[i].e_skip});
      chk($sformatf("R3 drive v%0d", i), {15'b0, bus_drive}, {15'b0, VECS[i].e_drv});
      chk($sformatf("R4 data v%0d", i), bus_data, VECS[i].e_dat);
      chk($sformatf("R7 ready v%0d", i), {15'b0, ready}, {15'b0, VECS[i].e_rdy});
    end

    // R1: reset mid-run while ready is set
    drive(ME, 1, 0, 0, '0);
    chk("R1 pre ready", {15'b0, ready}, 16'h1);
    rst_n = 0;
    drive(ME, 1, 0, 0, '0);
    chk("R1 mid ready", {15'b0, ready}, 16'h0);
    chk("R1 mid skip_n", {15'b0, skip_n}, 16'h1);
    chk("R1 mid data", bus_data, 16'h0);
    rst_n = 1;

    // R6 with R7: load on the clearing cycle is ignored
    drive(6'h00, 0, 0, 1, 16'h5555);
    drive(ME, 1, 1, 0, '0);
    chk("R5 data", bus_data, 16'h5555);
    drive(ME, 1, 0, 1, 16'h7777);
    chk("R7 ready before edge", {15'b0, ready}, 16'h1);
    drive(ME, 1, 0, 0, '0);
    chk("R6 ready after clear", {15'b0, ready}, 16'h0);
    chk("R9 data kept", bus_data, 16'h5555);
    chk("R9 skip_n", {15'b0, skip_n}, 16'h1);

    // R10: address one bit off in the top position
    drive(ME ^ 6'h20, 1, 0, 0, '0);
    chk("R10 drive", {15'b0, bus_drive}, 16'h0);
    chk("R10 data", bus_data, 16'h0);

    finish_run();
  end
endmodule